// File: doc/BRIEF.md
# Reset Sequencer and Armed Overflow Capture

This block belongs to the control section of a cascadable multiply-accumulate engine. It combines two reset sources into one internal reset. The first source is a power-on condition: the asynchronous `rst_ni` stays low until the supply is valid. The second is an active-low external reset pin with a glitch filter. While the internal reset is active, the control and configuration registers are held at their defaults.

The block also watches two overflow sources: the final adder and the field selector. It records each one in its own flag, so software can tell which source overflowed. An active-high pull-down enable drives the shared error line, and the pad built from it only ever pulls the line low. Several devices can therefore share one interrupt wire.

Software clears an error by writing 0 to that source's arm bit, and re-arms it by writing 1. A condition can be released only if the source was armed when its most recent overflow arrived. An overflow that arrives while the source is disarmed raises the line but leaves no flag. That condition stays stuck until software arms the source, lets a new overflow occur, and clears again.

Register writes come from an asynchronous strobe. Address and data are held stable while the strobe is high. The strobe is synchronized, and its rising edge performs the write.

Top module: `err_rst_ctrl`

## Requirements
- R1: After `rst_ni` rises, `sys_rst_o` stays high for exactly 4 clock edges (PorCycles) and is low after the 4th edge.
- R2: `ext_rst_ni` sampled low for at least 2 consecutive cycles (ExtMinLow) asserts `sys_rst_o`. A low pulse of one cycle has no effect. `sys_rst_o` stays asserted while the pin is low and drops within a few cycles after the pin returns high.
- R3: While `sys_rst_o` is high, the registers hold their defaults. In `ctrl_o`, arm bits [1:0] = 1, flag bits [3:2] = 0 and bits [15:4] = CtrlMiscDefault (12'h001). `cfg_o` = CfgDefault (16'h0A5C), and `err_od_en_o` = 0.
- R4: A rising edge on `wr_stb_i` writes `wr_data_i` to one register. `wr_addr_i` = 0 selects the control register: data[0] is the adder arm bit, data[1] the field-selector arm bit, data[15:4] the misc field, and data[3:2] are ignored. `wr_addr_i` = 1 selects `cfg_o`.
- R5: An overflow pulse on a source whose arm bit is 1 sets that source's flag and asserts `err_od_en_o`. The adder flag is `ctrl_o[2]` and the field-selector flag is `ctrl_o[3]`. The other flag is left unchanged.
- R6: A control write with a 0 in an arm bit disarms that source and clears its flag. It releases the source's error condition if the source was armed at its most recent overflow. A 1 arms the source without changing any flag.
- R7: An overflow on a disarmed source does not set its flag but does assert `err_od_en_o`. A later clear write does not release that condition until the source has been armed, has overflowed again, and has been cleared.
- R8: `err_od_en_o` is high exactly while at least one source holds an unreleased error condition. Any flag at 1 implies that `err_od_en_o` is high.
- R9: A write strobe that arrives while `sys_rst_o` is high has no effect on the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset (low until supply valid) |
| ext_rst_ni | input | 1 | External active-low reset pin, asynchronous |
| wr_stb_i | input | 1 | Asynchronous write strobe; rising edge performs the write |
| wr_addr_i | input | 1 | Register select: 0 control, 1 configuration |
| wr_data_i | input | 16 | Write data, stable while strobe is high |
| ovf_add_i | input | 1 | Final-adder overflow pulse |
| ovf_fld_i | input | 1 | Field-selector overflow pulse |
| sys_rst_o | output | 1 | Internal reset, active high |
| ctrl_o | output | 16 | Control register readback (arm, flag, misc) |
| cfg_o | output | 16 | Configuration register |
| err_od_en_o | output | 1 | Pull-down enable for the shared open-drain error line |

## Verification
The hardest state to reach from the ports is the stuck error condition. It needs an overflow that lands after a clear write and before the arm write, and then the exact recovery order: arm, a fresh overflow, and clear. The stimulus reaches it with a directed sequence. A long seeded random run of arm, clear and overflow operations on both sources follows, compared against a bench model of the protocol. Writes issued during an external reset, and a one-cycle reset glitch, are driven as directed cases.

// File: rtl/err_rst_pkg.sv
package err_rst_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned NUM_SRC = 2;

  // bit positions inside the control register
  localparam int unsigned ARM_LSB  = 0;
  localparam int unsigned FLAG_LSB = 2;
  localparam int unsigned MISC_LSB = 4;
  localparam int unsigned MISC_W   = DATA_W - MISC_LSB;

  typedef enum logic {
    ADDR_CTRL = 1'b0,
    ADDR_CFG  = 1'b1
  } reg_addr_e;

  typedef enum int unsigned {
    SRC_ADD = 0,
    SRC_FLD = 1
  } err_src_e;
endpackage

// File: rtl/ers_sync.sv
module ers_sync #(
  parameter int unsigned Stages   = 2,
  parameter logic        ResetVal = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [Stages-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {Stages{ResetVal}};
    else         chain_q <= {chain_q[Stages-2:0], d_i};
  end

  assign q_o = chain_q[Stages-1];
endmodule

// File: rtl/ers_rst_seq.sv
module ers_rst_seq #(
  parameter int unsigned PorCycles  = 4,
  parameter int unsigned ExtMinLow  = 2,
  parameter int unsigned SyncStages = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_rst_ni,
  output logic sys_rst_o
);
  localparam int unsigned PorW = $clog2(PorCycles + 1);
  localparam int unsigned ExtW = $clog2(ExtMinLow + 1);
  localparam logic [PorW-1:0] PorMax = PorW'(PorCycles);
  localparam logic [ExtW-1:0] ExtMax = ExtW'(ExtMinLow);

  logic [PorW-1:0] por_cnt_q;
  logic [ExtW-1:0] low_cnt_q;
  logic            ext_s;
  logic            por_busy;
  logic            ext_act;

  // power-on: count clocks after supply-valid, then hold
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 por_cnt_q <= '0;
    else if (por_cnt_q != PorMax) por_cnt_q <= por_cnt_q + 1'b1;
  end

  ers_sync #(.Stages(SyncStages), .ResetVal(1'b1)) u_ext_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ext_rst_ni),
    .q_o   (ext_s)
  );

  // glitch filter: consecutive low samples, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  low_cnt_q <= '0;
    else if (ext_s)               low_cnt_q <= '0;
    else if (low_cnt_q != ExtMax) low_cnt_q <= low_cnt_q + 1'b1;
  end

  assign por_busy  = (por_cnt_q != PorMax);
  assign ext_act   = (low_cnt_q == ExtMax);
  assign sys_rst_o = por_busy | ext_act;
endmodule

// File: rtl/ers_err_cell.sv
module ers_err_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sys_rst_i,
  input  logic wr_i,
  input  logic wr_arm_i,
  input  logic ovf_i,
  output logic armed_o,
  output logic flag_o,
  output logic cond_o
);
  logic armed_q, flag_q, cond_q, ok_q;
  logic armed_d, flag_d, cond_d, ok_d;

  always_comb begin
    armed_d = armed_q;
    flag_d  = flag_q;
    cond_d  = cond_q;
    ok_d    = ok_q;
    if (wr_i) begin
      if (wr_arm_i) begin
        armed_d = 1'b1;
      end else begin
        armed_d = 1'b0;
        flag_d  = 1'b0;
        if (ok_q) cond_d = 1'b0;
      end
    end
    // overflow takes priority and uses the pre-write arm state
    if (ovf_i) begin
      cond_d = 1'b1;
      if (armed_q) begin
        flag_d = 1'b1;
        ok_d   = 1'b1;
      end else begin
        ok_d   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      flag_q  <= 1'b0;
      cond_q  <= 1'b0;
      ok_q    <= 1'b1;
    end else if (sys_rst_i) begin
      armed_q <= 1'b1;
      flag_q  <= 1'b0;
      cond_q  <= 1'b0;
      ok_q    <= 1'b1;
    end else begin
      armed_q <= armed_d;
      flag_q  <= flag_d;
      cond_q  <= cond_d;
      ok_q    <= ok_d;
    end
  end

  assign armed_o = armed_q;
  assign flag_o  = flag_q;
  assign cond_o  = cond_q;
endmodule

// File: rtl/err_rst_ctrl.sv
module err_rst_ctrl
  import err_rst_pkg::*;
#(
  parameter int unsigned       PorCycles       = 4,
  parameter int unsigned       ExtMinLow       = 2,
  parameter int unsigned       SyncStages      = 2,
  parameter logic [MISC_W-1:0] CtrlMiscDefault = 12'h001,
  parameter logic [DATA_W-1:0] CfgDefault      = 16'h0A5C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_rst_ni,
  input  logic              wr_stb_i,
  input  logic              wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ovf_add_i,
  input  logic              ovf_fld_i,
  output logic              sys_rst_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] cfg_o,
  output logic              err_od_en_o
);
  logic                stb_s, stb_q, wr_fire;
  logic                wr_ctrl, wr_cfg;
  logic [MISC_W-1:0]   misc_q;
  logic [DATA_W-1:0]   cfg_q;
  logic [NUM_SRC-1:0]  ovf_vec, armed_vec, flag_vec, cond_vec;
  logic                unused_bits;

  ers_rst_seq #(
    .PorCycles (PorCycles),
    .ExtMinLow (ExtMinLow),
    .SyncStages(SyncStages)
  ) u_rst_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ext_rst_ni(ext_rst_ni),
    .sys_rst_o (sys_rst_o)
  );

  ers_sync #(.Stages(SyncStages), .ResetVal(1'b0)) u_stb_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (wr_stb_i),
    .q_o   (stb_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stb_q <= 1'b0;
    else         stb_q <= stb_s;
  end

  // edge consumed during reset, so a strobe in reset is lost
  assign wr_fire = stb_s & ~stb_q & ~sys_rst_o;
  assign wr_ctrl = wr_fire & (reg_addr_e'(wr_addr_i) == ADDR_CTRL);
  assign wr_cfg  = wr_fire & (reg_addr_e'(wr_addr_i) == ADDR_CFG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      misc_q <= CtrlMiscDefault;
      cfg_q  <= CfgDefault;
    end else if (sys_rst_o) begin
      misc_q <= CtrlMiscDefault;
      cfg_q  <= CfgDefault;
    end else begin
      if (wr_ctrl) misc_q <= wr_data_i[DATA_W-1:MISC_LSB];
      if (wr_cfg)  cfg_q  <= wr_data_i;
    end
  end

  assign ovf_vec[SRC_ADD] = ovf_add_i;
  assign ovf_vec[SRC_FLD] = ovf_fld_i;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
    ers_err_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sys_rst_i(sys_rst_o),
      .wr_i     (wr_ctrl),
      .wr_arm_i (wr_data_i[ARM_LSB+i]),
      .ovf_i    (ovf_vec[i]),
      .armed_o  (armed_vec[i]),
      .flag_o   (flag_vec[i]),
      .cond_o   (cond_vec[i])
    );
  end

  assign unused_bits = ^wr_data_i[MISC_LSB-1:FLAG_LSB];

  assign ctrl_o      = {misc_q, flag_vec, armed_vec};
  assign cfg_o       = cfg_q;
  assign err_od_en_o = |cond_vec;
endmodule

// File: rtl/err_rst_ctrl_chk.sv
module err_rst_ctrl_chk #(
  parameter int unsigned PorCycles  = 4,
  parameter logic [15:0] CfgDefault = 16'h0A5C
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sys_rst_o,
  input logic [15:0] ctrl_o,
  input logic [15:0] cfg_o,
  input logic        err_od_en_o,
  input logic        ovf_add_i,
  input logic        ovf_fld_i
);
  int unsigned cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cyc_q <= 0;
    else if (cyc_q < PorCycles) cyc_q <= cyc_q + 1;
  end

  a_r1_por_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q < PorCycles) |-> sys_rst_o);

  a_r3_cfg_default: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |=> (cfg_o == CfgDefault));

  a_r3_pin_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |=> !err_od_en_o);

  a_r5_add_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[0] && ovf_add_i && !sys_rst_o) |=> (ctrl_o[2] && err_od_en_o));

  a_r5_fld_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[1] && ovf_fld_i && !sys_rst_o) |=> (ctrl_o[3] && err_od_en_o));

  a_r7_add_unarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_o[0] && ovf_add_i && !sys_rst_o) |=> (!$rose(ctrl_o[2]) && err_od_en_o));

  a_r7_fld_unarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_o[1] && ovf_fld_i && !sys_rst_o) |=> (!$rose(ctrl_o[3]) && err_od_en_o));

  a_r8_flag_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[2] || ctrl_o[3]) |-> err_od_en_o);
endmodule

bind err_rst_ctrl err_rst_ctrl_chk #(
  .PorCycles (PorCycles),
  .CfgDefault(CfgDefault)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sys_rst_o  (sys_rst_o),
  .ctrl_o     (ctrl_o),
  .cfg_o      (cfg_o),
  .err_od_en_o(err_od_en_o),
  .ovf_add_i  (ovf_add_i),
  .ovf_fld_i  (ovf_fld_i)
);

// File: tb/err_rst_ctrl_bench.sv
module err_rst_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ext_rst_ni = 1'b1;
  logic        wr_stb_i = 1'b0;
  logic        wr_addr_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic        ovf_add_i = 1'b0;
  logic        ovf_fld_i = 1'b0;
  logic        sys_rst_o;
  logic [15:0] ctrl_o;
  logic [15:0] cfg_o;
  logic        err_od_en_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  localparam logic [15:0] CFG_DEF  = 16'h0A5C;
  localparam logic [11:0] MISC_DEF = 12'h001;

  // protocol model state
  logic [1:0] m_arm, m_flag, m_cond, m_ok;

  always #2 clk_i = ~clk_i;

  err_rst_ctrl u_err_rst_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .ext_rst_ni(ext_rst_ni),
    .wr_stb_i(wr_stb_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .ovf_add_i(ovf_add_i), .ovf_fld_i(ovf_fld_i), .sys_rst_o(sys_rst_o),
    .ctrl_o(ctrl_o), .cfg_o(cfg_o), .err_od_en_o(err_od_en_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  function automatic void m_reset();
    m_arm = 2'b11; m_flag = 2'b00; m_cond = 2'b00; m_ok = 2'b11;
  endfunction

  function automatic void m_write(input logic [1:0] arms);
    for (int i = 0; i < 2; i++) begin
      if (arms[i]) m_arm[i] = 1'b1;
      else begin
        m_arm[i] = 1'b0; m_flag[i] = 1'b0;
        if (m_ok[i]) m_cond[i] = 1'b0;
      end
    end
  endfunction

  function automatic void m_ovf(input int src);
    m_cond[src] = 1'b1;
    if (m_arm[src]) begin m_flag[src] = 1'b1; m_ok[src] = 1'b1; end
    else m_ok[src] = 1'b0;
  endfunction

  function automatic logic [4:0] m_expect();
    return {|m_cond, m_flag, m_arm};
  endfunction

  task automatic reg_write(input logic addr, input logic [15:0] data);
    @(negedge clk_i);
    wr_addr_i = addr; wr_data_i = data; wr_stb_i = 1'b1;
    repeat (4) @(negedge clk_i);
    wr_stb_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic ctrl_write(input logic [1:0] arms);
    reg_write(1'b0, {12'hABC, 2'b00, arms});
    m_write(arms);
  endtask

  task automatic pulse_ovf(input int src);
    @(negedge clk_i);
    if (src == 0) ovf_add_i = 1'b1; else ovf_fld_i = 1'b1;
    @(negedge clk_i);
    ovf_add_i = 1'b0; ovf_fld_i = 1'b0;
    @(negedge clk_i);
    m_ovf(src);
  endtask

  task automatic check_err(input string req);
    check(req, {27'd0, err_od_en_o, ctrl_o[3:0]}, {27'd0, m_expect()});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    bit seen;
    void'($urandom(32'h5EED));
    m_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: exactly PorCycles edges of internal reset
    for (int e = 1; e <= 4; e++) begin
      @(negedge clk_i);
      check("R1 por", {31'd0, sys_rst_o}, {31'd0, (e < 4)});
    end
    // R3 defaults
    check("R3 ctrl default", ctrl_o, {MISC_DEF, 2'b00, 2'b11});
    check("R3 cfg default", cfg_o, CFG_DEF);
    check("R3 pin", {31'd0, err_od_en_o}, 32'd0);

    // R4 writes; data[3:2] ignored
    reg_write(1'b1, 16'hBEEF);
    check("R4 cfg write", cfg_o, 16'hBEEF);
    reg_write(1'b0, 16'hABCF);
    check("R4 ctrl write", ctrl_o, 16'hABC3);

    // R5 armed capture on each source
    pulse_ovf(0);
    check_err("R5 add capture");
    check("R5 misc kept", {20'd0, ctrl_o[15:4]}, 32'hABC);
    // R6 clear adder only, then rearm
    ctrl_write(2'b10);
    check_err("R6 clear add");
    ctrl_write(2'b11);
    check_err("R6 rearm");
    pulse_ovf(1);
    check_err("R5 fld capture");
    ctrl_write(2'b01);
    check_err("R6 clear fld");
    ctrl_write(2'b11);

    // R7 overflow between clear and arm: stuck condition
    ctrl_write(2'b00);
    pulse_ovf(1);
    check_err("R7 unarmed not flagged");
    check("R7 pin raised", {31'd0, err_od_en_o}, 32'd1);
    ctrl_write(2'b11);
    ctrl_write(2'b00);
    check("R7 stuck pin", {31'd0, err_od_en_o}, 32'd1);
    ctrl_write(2'b11);
    pulse_ovf(1);
    check_err("R7 forced overflow");
    ctrl_write(2'b01);
    check_err("R7 recovered");
    check("R8 pin low", {31'd0, err_od_en_o}, 32'd0);
    ctrl_write(2'b11);

    // R8 random protocol mix against model
    for (int n = 0; n < 300; n++) begin
      int op = $urandom_range(0, 3);
      if (op < 2) pulse_ovf(op);
      else ctrl_write(2'($urandom_range(0, 3)));
      check_err("R8 random");
    end

    // R2 one-cycle glitch ignored
    reg_write(1'b1, 16'h1234);
    @(negedge clk_i); ext_rst_ni = 1'b0;
    @(negedge clk_i); ext_rst_ni = 1'b1;
    seen = 0;
    repeat (8) begin @(negedge clk_i); if (sys_rst_o) seen = 1; end
    check("R2 glitch ignored", {31'd0, seen}, 32'd0);
    check("R2 glitch cfg kept", cfg_o, 16'h1234);

    // R3/R9 held external reset with pending error and a write
    ctrl_write(2'b00);
    pulse_ovf(0);
    @(negedge clk_i); ext_rst_ni = 1'b0;
    repeat (6) @(negedge clk_i);
    check("R2 held asserts", {31'd0, sys_rst_o}, 32'd1);
    check("R3 ctrl in reset", ctrl_o, {MISC_DEF, 2'b00, 2'b11});
    check("R3 cfg in reset", cfg_o, CFG_DEF);
    check("R3 pin in reset", {31'd0, err_od_en_o}, 32'd0);
    m_reset();
    reg_write(1'b1, 16'h5555);
    ext_rst_ni = 1'b1;
    repeat (8) @(negedge clk_i);
    check("R2 released", {31'd0, sys_rst_o}, 32'd0);
    check("R9 write in reset lost", cfg_o, CFG_DEF);

    // R2 two-cycle low pulse is enough
    @(negedge clk_i); ext_rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    ext_rst_ni = 1'b1;
    seen = 0;
    repeat (8) begin @(negedge clk_i); if (sys_rst_o) seen = 1; end
    check("R2 min pulse", {31'd0, seen}, 32'd1);
    check("R2 min pulse released", {31'd0, sys_rst_o}, 32'd0);

    done = 1;
    summary();
    $finish;
  end
endmodule